// File: doc/BRIEF.md
# Vectored Interrupt Entry Address Generator

This block decides which pending exception or interrupt the core services next and computes the address of the handler entry it must jump to. Exceptions are resolved by fixed priority and always win over interrupts. Interrupts come either from six local hardware lines plus a software request, ranked inside the block, or from an external interrupt controller that supplies a ready-made vector number. A mode bit in the vector base word chooses between these two sources.

The target address is the 64 KB-aligned table base plus the entry number times a programmable entry stride of 4, 16, 64 or 256 bytes. All inputs are sampled on a rising clock edge. The result is presented one cycle later as a one-cycle take strobe, together with the entry number and target PC, which then stay held until the next take. After each take the block ignores requests for one cycle, so that the core can clear the serviced source.

Top module: `vec_entry_gen`

## Requirements
- R1: While `rst_n` is low, `take_o`, `entry_o` and `pc_o` are all zero.
- R2: If any bit of `exc_req_i` is set, the request with the lowest bit index is taken and `entry_o` equals that index (bit 0 = reset, entry 0; bit 8 = entry 8). This holds whatever the interrupt inputs, the mode and `gie_i` are.
- R3: Exception bit 1 (non-maskable interrupt, entry 1) is taken when `gie_i` is 0, and so is every other exception bit.
- R4: In internal mode (`vbr_i[0]` = 0), with `gie_i` = 1 and no exception pending, hardware line k gives entry 9+k, and the lowest-numbered active line wins. `sw_irq_i` gives entry 15, and only when no hardware line is active.
- R5: With `gie_i` = 0 and no exception pending, `hw_irq_i`, `sw_irq_i` and `ext_valid_i` cause no take.
- R6: In external mode (`vbr_i[0]` = 1), with `gie_i` = 1 and no exception pending, `ext_valid_i` = 1 gives an entry equal to `ext_vec_i`. `hw_irq_i` and `sw_irq_i` cause no take in this mode.
- R7: On a take, `pc_o` = {`vbr_i[31:16]`, 16'h0} + entry × stride. The stride is set by `vbr_i[2:1]`: 0 gives 4 bytes, 1 gives 16, 2 gives 64 and 3 gives 256. `vbr_i[15:3]` has no effect.
- R8: `take_o` rises in the cycle after the rising edge that sampled a qualifying request. It is never high in two consecutive cycles, and requests sampled while `take_o` is high are ignored.
- R9: `entry_o` and `pc_o` change only in a cycle where `take_o` is high, and they hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 9 | Pending exception requests; bit index = entry number |
| hw_irq_i | input | 6 | Hardware interrupt lines, line 0 highest priority |
| sw_irq_i | input | 1 | Software interrupt request (entry 15) |
| gie_i | input | 1 | Global enable for maskable interrupts |
| ext_valid_i | input | 1 | External controller vector valid |
| ext_vec_i | input | 6 | External controller vector number |
| vbr_i | input | 32 | Vector base word: [31:16] base, [2:1] stride code, [0] external mode |
| take_o | output | 1 | One-cycle take strobe |
| entry_o | output | 6 | Selected entry number |
| pc_o | output | 32 | Handler entry address |

## Verification
Every result of this block is due exactly one clock after the edge that sampled its inputs: the take strobe, the entry number and the PC all come from one register stage. The bench drives stimulus at the falling edge. Its behavioural model updates on the same rising edge as the design, and the outputs are compared with the model at the following falling edge, together with fixed expected constants for the directed cases. Held requests are followed over three successive falling edges, which checks the forced idle cycle after a take and confirms that entry and PC do not change while the strobe is low.

// File: rtl/vec_pkg.sv
// Package: shared constants and the control fields decoded from the vector base word.
// Assumes the base word keeps mode at bit 0 and stride code at bits 2:1.
package vec_pkg;

    localparam int MODE_BIT = 0;
    localparam int ESZ_LSB  = 1;
    localparam int ESZ_W    = 2;
    localparam int N_STRIDE = 1 << ESZ_W;

    typedef struct packed {
        logic [ESZ_W-1:0] esz;
        logic             ext_mode;
    } vbr_ctl_t;

    // Pull the mode and stride fields out of the base word
    function automatic vbr_ctl_t decode_vbr(input logic [ESZ_LSB+ESZ_W-1:0] low_bits);
        vbr_ctl_t c;
        c.ext_mode = low_bits[MODE_BIT];
        c.esz      = low_bits[ESZ_LSB +: ESZ_W];
        return c;
    endfunction

endpackage

// File: rtl/vec_first_one.sv
// Fixed-priority encoder: reports whether any request is set and the index of
// the lowest set bit. Assumes W >= 2.
module vec_first_one #(
    parameter int W  = 9,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [W:0]   seen;
    logic [W-1:0] grant;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_chain
            assign seen[g+1] = seen[g] | req[g];
            assign grant[g]  = req[g] & ~seen[g];
        end
    endgenerate

    assign any = seen[W];

    // Turn the one-hot grant into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/vec_addr_calc.sv
// Entry address computation: base + entry << (2*code + 2), with one shifted
// candidate per stride code. Assumes VEC_W + max shift fits the base alignment.
module vec_addr_calc #(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 6,
    parameter int BASE_LSB = 16,
    parameter int ESZ_W    = 2
) (
    input  logic [XLEN-BASE_LSB-1:0] base_hi,
    input  logic [ESZ_W-1:0]         esz,
    input  logic [VEC_W-1:0]         entry,
    output logic [XLEN-1:0]          pc
);
    localparam int NCAND = 1 << ESZ_W;

    logic [XLEN-1:0] wide_entry;
    logic [XLEN-1:0] cand [NCAND];

    assign wide_entry = {{(XLEN-VEC_W){1'b0}}, entry};

    genvar g;
    generate
        for (g = 0; g < NCAND; g++) begin : g_stride
            assign cand[g] = wide_entry << (2 * g + 2);
        end
    endgenerate

    // Add the selected offset to the aligned base
    always_comb begin
        pc = {base_hi, {BASE_LSB{1'b0}}} + cand[esz];
    end
endmodule

// File: rtl/vec_entry_gen.sv
// Vectored entry generator top. Resolves exceptions first (lowest index wins),
// then either the internally ranked interrupts or an external vector, gated by
// the global enable. Registers a one-cycle take strobe with entry and PC; one
// idle cycle follows every take. Synchronous active-low reset.
module vec_entry_gen #(
    parameter int XLEN     = 32,
    parameter int N_EXC    = 9,
    parameter int N_HW     = 6,
    parameter int VEC_W    = 6,
    parameter int BASE_LSB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXC-1:0] exc_req_i,
    input  logic [N_HW-1:0]  hw_irq_i,
    input  logic             sw_irq_i,
    input  logic             gie_i,
    input  logic             ext_valid_i,
    input  logic [VEC_W-1:0] ext_vec_i,
    input  logic [XLEN-1:0]  vbr_i,
    output logic             take_o,
    output logic [VEC_W-1:0] entry_o,
    output logic [XLEN-1:0]  pc_o
);
    import vec_pkg::*;

    localparam int EXC_IW = $clog2(N_EXC);
    localparam int IRQ_N  = N_HW + 1;
    localparam int IRQ_IW = $clog2(IRQ_N);
    localparam int CTL_W  = ESZ_LSB + ESZ_W;

    vbr_ctl_t          ctl;
    logic              exc_any;
    logic [EXC_IW-1:0] exc_idx;
    logic              irq_any;
    logic [IRQ_IW-1:0] irq_idx;
    logic              hit;
    logic [VEC_W-1:0]  nxt_entry;
    logic [XLEN-1:0]   nxt_pc;
    logic              vbr_unused;

    assign ctl        = decode_vbr(vbr_i[CTL_W-1:0]);
    assign vbr_unused = ^vbr_i[BASE_LSB-1:CTL_W];

    vec_first_one #(.W(N_EXC), .IW(EXC_IW)) u_exc_enc (
        .req (exc_req_i),
        .any (exc_any),
        .idx (exc_idx)
    );

    vec_first_one #(.W(IRQ_N), .IW(IRQ_IW)) u_irq_enc (
        .req ({sw_irq_i, hw_irq_i}),
        .any (irq_any),
        .idx (irq_idx)
    );

    // Choose the winning source and its entry number
    always_comb begin
        hit       = 1'b0;
        nxt_entry = '0;
        if (exc_any) begin
            hit       = 1'b1;
            nxt_entry = VEC_W'(exc_idx);
        end else if (gie_i && ctl.ext_mode) begin
            hit       = ext_valid_i;
            nxt_entry = ext_vec_i;
        end else if (gie_i) begin
            hit       = irq_any;
            nxt_entry = VEC_W'(N_EXC) + VEC_W'(irq_idx);
        end
    end

    vec_addr_calc #(
        .XLEN(XLEN), .VEC_W(VEC_W), .BASE_LSB(BASE_LSB), .ESZ_W(ESZ_W)
    ) u_addr (
        .base_hi (vbr_i[XLEN-1:BASE_LSB]),
        .esz     (ctl.esz),
        .entry   (nxt_entry),
        .pc      (nxt_pc)
    );

    // Output register: pulse on a new take, hold entry and PC otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            entry_o <= '0;
            pc_o    <= '0;
        end else if (!take_o && hit) begin
            take_o  <= 1'b1;
            entry_o <= nxt_entry;
            pc_o    <= nxt_pc;
        end else begin
            take_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/vec_entry_gen_chk.sv
// Checker for vec_entry_gen: temporal properties on its ports, attached by bind.
module vec_entry_gen_chk #(
    parameter int XLEN     = 32,
    parameter int N_EXC    = 9,
    parameter int VEC_W    = 6,
    parameter int BASE_LSB = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_EXC-1:0]         exc_req_i,
    input logic                     gie_i,
    input logic                     ext_valid_i,
    input logic [VEC_W-1:0]         ext_vec_i,
    input logic                     ext_mode,
    input logic [XLEN-BASE_LSB-1:0] base_hi,
    input logic                     take_o,
    input logic [VEC_W-1:0]         entry_o,
    input logic [XLEN-1:0]          pc_o
);
    assert_take_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ($stable(entry_o) && $stable(pc_o)));

    assert_exc_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && exc_req_i != '0) |=> (take_o && entry_o < VEC_W'(N_EXC)));

    assert_nmi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && exc_req_i[1] && !exc_req_i[0]) |=> (take_o && entry_o == VEC_W'(1)));

    assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && exc_req_i == '0 && !gie_i) |=> !take_o);

    assert_ext_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && exc_req_i == '0 && gie_i && ext_mode && ext_valid_i)
        |=> (take_o && entry_o == $past(ext_vec_i)));

    assert_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (pc_o[XLEN-1:BASE_LSB] == $past(base_hi)));
endmodule

bind vec_entry_gen vec_entry_gen_chk #(
    .XLEN(XLEN), .N_EXC(N_EXC), .VEC_W(VEC_W), .BASE_LSB(BASE_LSB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req_i   (exc_req_i),
    .gie_i       (gie_i),
    .ext_valid_i (ext_valid_i),
    .ext_vec_i   (ext_vec_i),
    .ext_mode    (vbr_i[0]),
    .base_hi     (vbr_i[XLEN-1:BASE_LSB]),
    .take_o      (take_o),
    .entry_o     (entry_o),
    .pc_o        (pc_o)
);

// File: tb/vec_entry_gen_bench.sv
`timescale 1ns/1ps
// Bench: behavioural model updated on each rising edge, outputs compared on
// each falling edge, plus directed checks against fixed constants.
module vec_entry_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  exc_req = '0;
    logic [5:0]  hw_irq = '0;
    logic        sw_irq = 1'b0;
    logic        gie = 1'b0;
    logic        ext_valid = 1'b0;
    logic [5:0]  ext_vec = '0;
    logic [31:0] vbr = '0;
    logic        take;
    logic [5:0]  entry;
    logic [31:0] pc;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vec_entry_gen u_vec_entry_gen (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .hw_irq_i(hw_irq),
        .sw_irq_i(sw_irq), .gie_i(gie), .ext_valid_i(ext_valid),
        .ext_vec_i(ext_vec), .vbr_i(vbr), .take_o(take), .entry_o(entry), .pc_o(pc)
    );

    // Reference model state
    bit          m_take = 1'b0;
    int          m_entry = 0;
    logic [31:0] m_pc = '0;
    string       m_ttag = "R1";
    string       m_etag = "R1";

    always @(posedge clk) begin
        bit    found;
        int    e;
        string tg;
        if (!rst_n) begin
            m_take = 1'b0; m_entry = 0; m_pc = '0; m_ttag = "R1"; m_etag = "R1";
        end else if (m_take) begin
            m_take = 1'b0; m_ttag = "R8"; m_etag = "R9";
        end else begin
            found = 1'b0; e = 0; tg = "R5";
            for (int i = 0; i < 9; i++)
                if (!found && exc_req[i]) begin
                    found = 1'b1; e = i; tg = (i == 1) ? "R3" : "R2";
                end
            if (!found && gie) begin
                if (vbr[0]) begin
                    tg = "R6";
                    if (ext_valid) begin found = 1'b1; e = int'(ext_vec); end
                end else begin
                    tg = "R4";
                    for (int k = 0; k < 6; k++)
                        if (!found && hw_irq[k]) begin found = 1'b1; e = 9 + k; end
                    if (!found && sw_irq) begin found = 1'b1; e = 15; end
                end
            end
            if (found) begin
                m_take = 1'b1; m_entry = e;
                m_pc = (vbr & 32'hFFFF_0000) + 32'(e * (1 << (2 * int'(vbr[2:1]) + 2)));
                m_ttag = tg; m_etag = tg;
            end else begin
                m_take = 1'b0; m_ttag = tg; m_etag = "R9";
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance to the next falling edge and compare against the model
    task automatic tick();
        @(negedge clk);
        chk(m_ttag, {31'b0, take}, {31'b0, m_take});
        chk(m_etag, {26'b0, entry}, 32'(m_entry));
        chk((m_take ? "R7" : "R9"), pc, m_pc);
    endtask

    task automatic idle();
        exc_req = '0; hw_irq = '0; sw_irq = 1'b0; ext_valid = 1'b0; ext_vec = '0;
    endtask

    task automatic expect_take(input string tag, input int e, input logic [31:0] p);
        chk(tag, {31'b0, take}, 32'd1);
        chk(tag, {26'b0, entry}, 32'(e));
        chk("R7", pc, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {31'b0, take}, 32'd0);
        chk("R1", {26'b0, entry}, 32'd0);
        chk("R1", pc, 32'd0);
        rst_n = 1'b1;
        tick();

        // R4 internal line 2, stride 4, junk low bits (R7)
        vbr = 32'h1234_FFF8; gie = 1'b1; hw_irq = 6'b000100;
        tick(); expect_take("R4", 11, 32'h1234_002C);
        idle(); tick();

        // R4 lowest line wins over higher line and software
        vbr = 32'h1234_0002; hw_irq = 6'b101000; sw_irq = 1'b1;
        tick(); expect_take("R4", 12, 32'h1234_00C0);
        idle(); tick();

        // R4 software request alone, stride 64
        vbr = 32'h0005_0004; sw_irq = 1'b1;
        tick(); expect_take("R4", 15, 32'h0005_03C0);
        idle(); tick();

        // R2 exception beats interrupts, stride 256
        vbr = 32'h00FF_0006; exc_req = 9'b100100000; hw_irq = 6'h3F;
        tick(); expect_take("R2", 5, 32'h00FF_0500);
        idle(); tick();

        // R3 NMI with global enable off
        gie = 1'b0; exc_req = 9'b000000010;
        tick(); expect_take("R3", 1, 32'h00FF_0100);
        idle(); tick();

        // R5 masked interrupts: no take, entry held (R9)
        hw_irq = 6'h3F; sw_irq = 1'b1; ext_valid = 1'b1;
        tick(); chk("R5", {31'b0, take}, 32'd0); chk("R9", {26'b0, entry}, 32'd1);
        tick(); chk("R5", {31'b0, take}, 32'd0);
        idle(); tick();

        // R6 external mode ignores local lines
        vbr = 32'hABCD_0007; gie = 1'b1; hw_irq = 6'h3F; sw_irq = 1'b1;
        tick(); chk("R6", {31'b0, take}, 32'd0);
        ext_valid = 1'b1; ext_vec = 6'd37;
        tick(); expect_take("R6", 37, 32'hABCD_2500);
        idle(); tick();

        // R7 largest external entry with largest stride
        vbr = 32'hFFFF_0007; ext_valid = 1'b1; ext_vec = 6'd63;
        tick(); expect_take("R7", 63, 32'hFFFF_3F00);
        idle(); tick();

        // R8 held request: take, forced idle, take again
        vbr = 32'h0001_0000; exc_req = 9'b000010000;
        tick(); expect_take("R8", 4, 32'h0001_0010);
        tick(); chk("R8", {31'b0, take}, 32'd0); chk("R9", {26'b0, entry}, 32'd4);
        tick(); chk("R8", {31'b0, take}, 32'd1);
        idle(); tick();

        // R2 reset request has top priority
        exc_req = 9'h1FF;
        tick(); expect_take("R2", 0, 32'h0001_0000);
        idle(); tick();

        // Random traffic compared against the model each cycle
        for (int n = 0; n < 600; n++) begin
            exc_req   = (($urandom % 6) == 0) ? 9'(1 << ($urandom % 9)) : 9'b0;
            hw_irq    = (($urandom % 3) == 0) ? 6'($urandom) : 6'b0;
            sw_irq    = (($urandom % 4) == 0);
            gie       = (($urandom % 4) != 0);
            ext_valid = (($urandom % 3) == 0);
            ext_vec   = 6'($urandom);
            vbr       = $urandom;
            tick();
        end
        idle(); tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule